// File: doc/BRIEF.md
# Asymmetric SCL Clock Generator

This block produces the serial clock for a two-wire bus master. A 32-bit divider word sets the low-phase length and the high-phase length separately, so the clock can spend more time low than high. Both phases are built from a divide-by-8 prescaler that advances a phase counter. The counter reloads at every phase boundary.

Two single-cycle strobes go with the clock. The data strobe fires halfway through each low phase, which is the point where the byte engine may change the data line. The sample strobe fires in the first cycle after each rising edge, which is the point where the data line is read. When the enable input is low, the clock rests high and all internal counting is cleared. The next clock cycle after enable is sampled high always begins with a low phase.

The divider word is captured only when a low phase begins. A software write therefore never shortens or stretches a phase that is already running. The block targets minimum phase times such as 4.7 µs low / 4.0 µs high (standard speed) and 1.3 µs low / 0.6 µs high (fast speed). Software meets these by choosing the two halves of the divider word.

Top module: `scl_phase_gen`

## Requirements
- R1: While `rst_n` is low or `enable` is low, `scl_out` is 1 and both strobes are 0. When `enable` drops, `scl_out` is 1 from the next cycle on, and any phase or strobe still pending is dropped.
- R2: In the clock cycle that follows the first edge at which `enable` is sampled high from idle, `scl_out` is 0, so the first phase is always a low phase.
- R3: Each low phase lasts exactly 8 × (L + 1) clock cycles, where L is `div_word[15:0]`.
- R4: Each high phase lasts exactly 8 × (H + 1) clock cycles, where H is `div_word[31:16]`.
- R5: `sda_stb` is 1 for exactly one cycle per low phase. It falls on low-phase cycle index 4 × (L + 1), counting the first low cycle as index 0, and never while `scl_out` is 1.
- R6: `sample_stb` is 1 for exactly one cycle, the first cycle in which `scl_out` is 1 after having been 0. It is never 1 at the same time as `sda_stb`.
- R7: Both halves of `div_word` are captured when a low phase begins. A change to `div_word` during a low phase affects neither that low phase nor the high phase that follows it.
- R8: A change to `div_word` during a high phase does not alter that high phase, and it takes effect from the next low phase.
- R9: With L = 0 and H = 0, the clock period is the minimum of 8 low cycles plus 8 high cycles, with `sda_stb` on low index 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the clock while high; idles it high while low |
| div_word | input | 32 | Divider word: high-phase count in bits 31:16, low-phase count in bits 15:0 |
| scl_out | output | 1 | Generated serial clock |
| sda_stb | output | 1 | One-cycle strobe at the middle of each low phase |
| sample_stb | output | 1 | One-cycle strobe in the first cycle after each rising edge |

## Verification
The hardest case to reach from the ports is a divider write that lands in the middle of a phase. The design must keep running on its captured copy while the input word already shows a new value. The stimulus writes one new word partway through a high phase and a second word a few cycles into the following low phase. The expected event stamps are then computed so that the old high count still governs the high phase after the second write. A separate run drops `enable` after a falling edge but before the midpoint, to show that a pending data strobe is discarded.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } phase_t;

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
   parameter int PRESCALE = 8,
   localparam int PS_W    = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   output logic            tick,
   output logic [PS_W-1:0] pos
);

   generate
      if (PRESCALE < 2) begin : g_bad
         $error("scl_prescaler: PRESCALE must be at least 2");
      end
   endgenerate

   generate
      if ((PRESCALE & (PRESCALE - 1)) == 0) begin : g_pow2
         // natural wrap of a power-of-two counter
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     pos <= '0;
            else if (clear) pos <= '0;
            else            pos <= pos + 1'b1;
         end
         assign tick = &pos;
      end else begin : g_cmp
         logic at_end;
         assign at_end = (pos == PS_W'(PRESCALE - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pos <= '0;
            else if (clear)  pos <= '0;
            else if (at_end) pos <= '0;
            else             pos <= pos + 1'b1;
         end
         assign tick = at_end;
      end
   endgenerate

endmodule

// File: rtl/scl_phase_counter.sv
module scl_phase_counter #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             tick,
   input  logic [DIV_W-1:0] limit,
   output logic [DIV_W-1:0] count,
   output logic             last
);

   generate
      if (DIV_W < 1) begin : g_bad
         $error("scl_phase_counter: DIV_W must be positive");
      end
   endgenerate

   assign last = tick && (count == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count <= '0;
      else if (clear) count <= '0;
      else if (last)  count <= '0;
      else if (tick)  count <= count + 1'b1;
   end

endmodule

// File: rtl/scl_div_latch.sv
module scl_div_latch #(
   parameter int DIV_W  = 16,
   localparam int WORD_W = 2 * DIV_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] word,
   output logic [DIV_W-1:0]  lo_cnt,
   output logic [DIV_W-1:0]  hi_cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_cnt <= '0;
         hi_cnt <= '0;
      end else if (load) begin
         lo_cnt <= word[DIV_W-1:0];
         hi_cnt <= word[WORD_W-1:DIV_W];
      end
   end

endmodule

// File: rtl/scl_mid_detect.sv
module scl_mid_detect #(
   parameter int DIV_W    = 16,
   parameter int PRESCALE = 8,
   localparam int PS_W    = (PRESCALE > 1) ? $clog2(PRESCALE) : 1,
   localparam int IDX_W   = DIV_W + PS_W + 1
) (
   input  logic [DIV_W-1:0] count,
   input  logic [PS_W-1:0]  pos,
   input  logic [DIV_W-1:0] lo_cnt,
   output logic             hit
);

   generate
      if ((PRESCALE % 2) != 0) begin : g_bad
         $error("scl_mid_detect: PRESCALE must be even for an exact midpoint");
      end
   endgenerate

   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] mid;

   assign idx = IDX_W'(count) * IDX_W'(PRESCALE) + IDX_W'(pos);
   assign mid = (IDX_W'(lo_cnt) + IDX_W'(1)) * IDX_W'(PRESCALE / 2);
   assign hit = (idx == mid);

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
   parameter int DIV_W    = 16,
   parameter int PRESCALE = 8,
   localparam int WORD_W  = 2 * DIV_W,
   localparam int PS_W    = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [WORD_W-1:0] div_word,
   output logic              scl_out,
   output logic              sda_stb,
   output logic              sample_stb
);
   import scl_gen_pkg::*;

   phase_t state_q, state_d;

   logic              pre_tick;
   logic [PS_W-1:0]   pre_pos;
   logic [DIV_W-1:0]  ph_count;
   logic              ph_last;
   logic [DIV_W-1:0]  lo_cnt, hi_cnt;
   logic [DIV_W-1:0]  limit;
   logic              mid_hit;
   logic              start_low;
   logic              clr;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PH_IDLE: if (enable) state_d = PH_LOW;
         PH_LOW: begin
            if (!enable)     state_d = PH_IDLE;
            else if (ph_last) state_d = PH_HIGH;
         end
         PH_HIGH: begin
            if (!enable)     state_d = PH_IDLE;
            else if (ph_last) state_d = PH_LOW;
         end
         default: state_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PH_IDLE;
      else        state_q <= state_d;
   end

   assign start_low = (state_d == PH_LOW) && (state_q != PH_LOW);
   assign clr       = (state_d != state_q) || (state_q == PH_IDLE);
   assign limit     = (state_q == PH_LOW) ? lo_cnt : hi_cnt;

   scl_prescaler #(.PRESCALE(PRESCALE)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clr),
      .tick  (pre_tick),
      .pos   (pre_pos)
   );

   scl_phase_counter #(.DIV_W(DIV_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clr),
      .tick  (pre_tick),
      .limit (limit),
      .count (ph_count),
      .last  (ph_last)
   );

   scl_div_latch #(.DIV_W(DIV_W)) u_lat (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (start_low),
      .word   (div_word),
      .lo_cnt (lo_cnt),
      .hi_cnt (hi_cnt)
   );

   scl_mid_detect #(.DIV_W(DIV_W), .PRESCALE(PRESCALE)) u_mid (
      .count  (ph_count),
      .pos    (pre_pos),
      .lo_cnt (lo_cnt),
      .hit    (mid_hit)
   );

   assign scl_out    = (state_q != PH_LOW);
   assign sda_stb    = (state_q == PH_LOW) && mid_hit;
   assign sample_stb = (state_q == PH_HIGH) && (ph_count == '0) && (pre_pos == '0);

endmodule

// File: rtl/scl_phase_gen_chk.sv
module scl_phase_gen_chk #(
   parameter int DIV_W    = 16,
   parameter int PRESCALE = 8,
   localparam int LEN_W   = DIV_W + ((PRESCALE > 1) ? $clog2(PRESCALE) : 1) + 2
) (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic scl_out,
   input logic sda_stb,
   input logic sample_stb
);

   logic [LEN_W-1:0] low_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       low_len <= '0;
      else if (!scl_out) low_len <= low_len + 1'b1;
      else              low_len <= '0;
   end

   // R1: a disabled cycle leaves the clock high in the next cycle
   a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> scl_out);

   // R2: enabling from idle begins with a low phase
   a_r2_first_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(enable) |=> !scl_out);

   // R3: a completed low phase is a whole number of prescaler periods
   a_r3_low_multiple: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> ((low_len % LEN_W'(PRESCALE)) == '0 && low_len != '0));

   // R5: the data strobe only occurs while the clock is low
   a_r5_mid_in_low: assert property (@(posedge clk) disable iff (!rst_n)
      sda_stb |-> !scl_out);

   // R6: the sample strobe marks the rising edge
   a_r6_rise_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> (scl_out && !$past(scl_out)));

   // R6: the two strobes never coincide
   a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sda_stb, sample_stb}));

endmodule

bind scl_phase_gen scl_phase_gen_chk #(.DIV_W(DIV_W), .PRESCALE(PRESCALE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .scl_out    (scl_out),
   .sda_stb    (sda_stb),
   .sample_stb (sample_stb)
);

// File: tb/sim_scl_phase_gen.sv
`timescale 1ns/1ps
module sim_scl_phase_gen;

   localparam int K_FALL = 0;
   localparam int K_MID  = 1;
   localparam int K_RISE = 2;

   typedef struct {
      int     kind;
      longint stamp;
      string  req;
   } ev_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [31:0] div_word = '0;
   logic        scl_out, sda_stb, sample_stb;

   longint cyc = 0;
   int     n_chk = 0;
   int     n_fail = 0;
   bit     mon_on = 1'b0;
   bit     prev_scl = 1'b1;
   bit     done = 1'b0;
   ev_t    exp_q[$];

   always #10 clk = ~clk;   // 50 MHz
   always @(posedge clk) cyc <= cyc + 1;

   scl_phase_gen u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .div_word   (div_word),
      .scl_out    (scl_out),
      .sda_stb    (sda_stb),
      .sample_stb (sample_stb)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input int lo, input int hi);
      return {hi[15:0], lo[15:0]};
   endfunction

   task automatic push(input int kind, input longint stamp, input string req);
      ev_t e;
      e.kind = kind; e.stamp = stamp; e.req = req;
      exp_q.push_back(e);
   endtask

   // one full period starting at falling-edge stamp f
   task automatic push_period(input longint f, input int lo, input int hi,
                              input string rq_lo, input string rq_hi,
                              output longint nf);
      push(K_FALL, f, rq_hi);
      push(K_MID,  f + 4 * (lo + 1), "R5");
      push(K_RISE, f + 8 * (lo + 1), rq_lo);
      nf = f + 8 * (lo + 1) + 8 * (hi + 1);
   endtask

   task automatic got(input int kind);
      ev_t e;
      if (exp_q.size() == 0) begin
         check(1'b0, "R1", "unexpected event kind", kind, -1);
      end else begin
         e = exp_q.pop_front();
         check(e.kind == kind, e.req, "event kind", kind, e.kind);
         check(e.stamp == cyc, e.req, "event cycle", cyc, e.stamp);
      end
   endtask

   // monitor: samples outputs on the falling clock edge
   always @(negedge clk) begin
      if (mon_on) begin
         if (scl_out === 1'b0 && prev_scl) got(K_FALL);
         if (sda_stb === 1'b1) got(K_MID);
         if (sample_stb === 1'b1) begin
            got(K_RISE);
            check(!prev_scl && scl_out === 1'b1, "R6", "strobe on rising edge",
                  {prev_scl, scl_out}, 2'b01);
         end
         prev_scl = (scl_out === 1'b1);
      end
   end

   task automatic wait_until(input longint t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic begin_run(input logic [31:0] w, output longint f);
      div_word = w;
      enable   = 1'b1;
      f        = cyc + 1;
   endtask

   task automatic end_run(input longint s);
      wait_until(s);
      enable = 1'b0;
      @(negedge clk);
      check(scl_out === 1'b1, "R1", "scl high after disable", scl_out, 1);
      repeat (40) @(negedge clk);
      check(exp_q.size() == 0, "R1", "pending events left", exp_q.size(), 0);
      check(scl_out === 1'b1 && !sda_stb && !sample_stb, "R1", "idle outputs",
            {scl_out, sda_stb, sample_stb}, 3'b100);
   endtask

   initial begin
      longint f, nf;
      repeat (3) @(negedge clk);
      check(scl_out === 1'b1, "R1", "scl in reset", scl_out, 1);
      check(!sda_stb && !sample_stb, "R1", "strobes in reset",
            {sda_stb, sample_stb}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      div_word = mk(5, 5);   // enable low: word must have no effect
      repeat (20) @(negedge clk);
      check(scl_out === 1'b1, "R1", "scl while disabled", scl_out, 1);
      mon_on = 1'b1;

      // run 1: L=3 (odd), H=1, three periods, stop in the last high cycle
      begin_run(mk(3, 1), f);
      push_period(f, 3, 1, "R3", "R2", nf);
      push_period(nf, 3, 1, "R3", "R4", nf);
      push_period(nf, 3, 1, "R3", "R4", nf);
      end_run(nf - 1);

      // run 2: minimum divisors, stop after fall but before the midpoint
      @(negedge clk);
      begin_run(mk(0, 0), f);
      push_period(f, 0, 0, "R9", "R2", nf);
      push_period(nf, 0, 0, "R9", "R9", nf);
      push(K_FALL, nf, "R9");
      end_run(nf + 2);

      // run 3: L=2 (even midpoint), H=5
      @(negedge clk);
      begin_run(mk(2, 5), f);
      push_period(f, 2, 5, "R3", "R2", nf);
      push_period(nf, 2, 5, "R3", "R4", nf);
      end_run(nf - 1);

      // run 4: divider writes in the middle of phases
      @(negedge clk);
      begin
         longint f1, f2, f3, f4, f5;
         begin_run(mk(2, 1), f1);
         push_period(f1, 2, 1, "R3", "R2", f2);
         push_period(f2, 1, 3, "R8", "R8", f3);   // new word from high write
         push_period(f3, 0, 0, "R7", "R7", f4);   // high of period 2 kept H=3
         push_period(f4, 0, 0, "R7", "R7", f5);
         wait_until(f1 + 30);                     // inside first high phase
         div_word = mk(1, 3);
         wait_until(f2 + 3);                      // inside second low phase
         div_word = mk(0, 0);
         end_run(f5 - 1);
      end

      mon_on = 1'b0;
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL R1 watchdog: actual %0d expected %0d", cyc, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule